// File: doc/BRIEF.md
# Latched serial-to-parallel shift register

The block takes a serial bit stream on one clock and presents it as an 8-bit parallel word on a second, independent clock. A chain of shift flops samples the serial input on each rising shift-clock edge. A rising storage-clock edge copies the whole chain into a holding register. The holding register drives the parallel outputs. Those outputs can be released to high impedance, so several blocks can share one bus.

The last shift stage also appears on a cascade output that is never tri-stated. Wiring it to the serial input of a second instance makes a longer register, 16 bits for two instances. An active-low asynchronous clear empties the shift chain at once and leaves the holding register, and so the visible parallel word, untouched.

Top module: `latched_sipo`

## Requirements
- R1: While `rst_ni` is low, every shift stage is 0 and `cascade_o` is 0, without waiting for any clock edge. A storage edge taken during the clear loads all zeros.
- R2: On each rising `shift_clk_i` edge, `ser_i` enters stage 0 and stage k moves to stage k+1. After eight edges, the first bit shifted sits in stage 7.
- R3: `cascade_o` always equals stage 7, the most significant shift stage, and changes only on a shift edge or a clear.
- R4: On each rising `store_clk_i` edge, the holding register takes the shift chain. With the outputs enabled, `par_o[i]` shows stage i.
- R5: Asserting the clear leaves the holding register, and so `par_o`, unchanged.
- R6: Shift edges with no storage edge leave `par_o` unchanged.
- R7: With `oe_ni` high, all eight `par_o` bits are high-impedance. With `oe_ni` low, they drive the holding register.
- R8: `oe_ni` has no effect on `cascade_o` or on shifting.
- R9: When the shift and storage clocks rise together, the holding register takes the chain contents from before that shift.
- R10: Two instances chained from `cascade_o` to `ser_i` form a 16-bit register. After 16 edges, with the word sent most significant bit first, the second instance holds the upper byte and the first holds the lower byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_i | input | 1 | Serial data into stage 0 |
| shift_clk_i | input | 1 | Shift clock, rising edge |
| rst_ni | input | 1 | Active-low asynchronous clear of the shift chain only |
| store_clk_i | input | 1 | Storage clock, rising edge, loads the holding register |
| oe_ni | input | 1 | Active-low output enable for `par_o` |
| par_o | output | 8 | Parallel outputs from the holding register, three-state |
| cascade_o | output | 1 | Last shift stage, always driven |

## Verification
A shift edge and a storage edge can land in the same instant. In that case, the holding register must pick up the chain value from before the new bit arrives. The bench provokes this by raising both clocks in the same time step after a known partial load. It judges the result from the parallel word, which must equal the previous chain state, and then from a second storage edge, which must show the shifted value. The clear can also meet a loaded holding register between clock edges. That case is judged by the parallel word staying put while the cascade output drops at once.

// File: rtl/latched_sipo_pkg.sv
package latched_sipo_pkg;
  localparam int unsigned SIPO_WIDTH = 8;
endpackage

// File: rtl/sipo_shift_stage.sv
module sipo_shift_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  output logic [W-1:0] stages_o,
  output logic         tail_o
);
  for (genvar g = 0; g < W; g++) begin : g_stage
    logic d;
    logic bit_q;
    if (g == 0) begin : g_head
      assign d = ser_i;
    end else begin : g_link
      assign d = stages_o[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bit_q <= 1'b0;
      else         bit_q <= d;
    end
    assign stages_o[g] = bit_q;
  end

  assign tail_o = stages_o[W-1];
endmodule

// File: rtl/sipo_hold_stage.sv
module sipo_hold_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // no reset: the clear must not reach the visible word
  always_ff @(posedge clk_i) begin
    q_o <= d_i;
  end
endmodule

// File: rtl/latched_sipo.sv
module latched_sipo
  import latched_sipo_pkg::*;
#(
  parameter int unsigned W = SIPO_WIDTH
) (
  input  logic         ser_i,
  input  logic         shift_clk_i,
  input  logic         rst_ni,
  input  logic         store_clk_i,
  input  logic         oe_ni,
  output logic [W-1:0] par_o,
  output logic         cascade_o
);
  logic [W-1:0] shift_q;
  logic [W-1:0] hold_q;

  sipo_shift_stage #(.W(W)) u_shift (
    .clk_i   (shift_clk_i),
    .rst_ni  (rst_ni),
    .ser_i   (ser_i),
    .stages_o(shift_q),
    .tail_o  (cascade_o)
  );

  sipo_hold_stage #(.W(W)) u_hold (
    .clk_i(store_clk_i),
    .d_i  (shift_q),
    .q_o  (hold_q)
  );

  for (genvar g = 0; g < W; g++) begin : g_drv
    assign par_o[g] = oe_ni ? 1'bz : hold_q[g];
  end
endmodule

// File: rtl/latched_sipo_chk.sv
module latched_sipo_chk #(
  parameter int unsigned W = 8
) (
  input logic         shift_clk_i,
  input logic         store_clk_i,
  input logic         rst_ni,
  input logic         ser_i,
  input logic         cascade_o,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] hold_q
);
  // expected chain after the next shift edge; invalidated by any clear
  logic         exp_v;
  logic [W-1:0] exp_q;

  always_ff @(posedge shift_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_v <= 1'b0;
      exp_q <= '0;
    end else begin
      exp_v <= 1'b1;
      exp_q <= {shift_q[W-2:0], ser_i};
    end
  end

  assert_shift_model_R2: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    exp_v |-> shift_q == exp_q);

  assert_cascade_tail_R3: assert property (@(posedge shift_clk_i) disable iff (!rst_ni)
    exp_v |-> cascade_o == exp_q[W-1]);

  assert_clear_empty_R1: assert property (@(posedge store_clk_i) disable iff (rst_ni)
    1'b1 |-> (shift_q == '0 && cascade_o == 1'b0));

  assert_store_capture_R4: assert property (@(posedge store_clk_i) disable iff (!rst_ni)
    1'b1 |=> hold_q == $past(shift_q));
endmodule

bind latched_sipo latched_sipo_chk #(.W(W)) u_chk (
  .shift_clk_i(shift_clk_i),
  .store_clk_i(store_clk_i),
  .rst_ni     (rst_ni),
  .ser_i      (ser_i),
  .cascade_o  (cascade_o),
  .shift_q    (shift_q),
  .hold_q     (hold_q)
);

// File: tb/sim_latched_sipo.sv
module sim_latched_sipo;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic shift_clk, store_clk, rst_n, oe_n, ser;
  tri0 [7:0] par0;
  tri0 [7:0] par1;
  logic casc0, casc1;

  latched_sipo u0 (
    .ser_i(ser), .shift_clk_i(shift_clk), .rst_ni(rst_n), .store_clk_i(store_clk),
    .oe_ni(oe_n), .par_o(par0), .cascade_o(casc0)
  );
  latched_sipo u1 (
    .ser_i(casc0), .shift_clk_i(shift_clk), .rst_ni(rst_n), .store_clk_i(store_clk),
    .oe_ni(oe_n), .par_o(par1), .cascade_o(casc1)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  logic [15:0] model;   // chain: u0 stages [7:0], u1 stages [15:8]
  logic [15:0] latched;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic shift1(input logic b);
    ser = b;
    #2 shift_clk = 1'b1;
    #4 shift_clk = 1'b0;
    #2;
    model = {model[14:0], b};
  endtask

  task automatic store1();
    #2 store_clk = 1'b1;
    #4 store_clk = 1'b0;
    #2;
    latched = model;
  endtask

  task automatic both1(input logic b);
    ser = b;
    #2 begin shift_clk = 1'b1; store_clk = 1'b1; end
    #4 begin shift_clk = 1'b0; store_clk = 1'b0; end
    #2;
    latched = model;
    model = {model[14:0], b};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; oe_n = 1'b0; shift_clk = 1'b0; store_clk = 1'b0; ser = 1'b0;
    model = '0; latched = '0;
    #10;
    store1();
    chk("R1 reset par", {par1, par0}, 16'h0000);
    chk("R1 reset cascade", {15'd0, casc0}, 16'h0000);
    rst_n = 1'b1;
    #4;

    // R2/R3/R4: every byte value, MSB first
    for (int v = 0; v < 256; v++) begin
      for (int i = 7; i >= 0; i--) begin
        shift1(v[i]);
        chk("R3 cascade", {15'd0, casc0}, {15'd0, model[7]});
      end
      store1();
      chk("R2 byte", {8'd0, par0}, v[15:0]);
      chk("R4 chain latch", {par1, par0}, latched);
    end

    // R6: shifts without storage leave the outputs alone
    for (int i = 0; i < 3; i++) shift1(1'b1);
    chk("R6 hold", {par1, par0}, latched);

    // R9: simultaneous edges capture pre-shift contents
    for (int i = 15; i >= 0; i--) shift1(i[0] ^ i[2]);
    store1();
    for (int i = 7; i >= 1; i--) shift1(8'hA5 >> i);
    both1(1'b1);
    chk("R9 simultaneous", {par1, par0}, latched);
    store1();
    chk("R9 after store", {par1, par0}, model);

    // R7: release to Z (tri0 nets read 0), then drive again
    for (int i = 0; i < 16; i++) shift1(1'b1);
    store1();
    chk("R7 enabled", {par1, par0}, 16'hFFFF);
    oe_n = 1'b1;
    #1;
    chk("R7 released", {par1, par0}, 16'h0000);

    // R8: cascade and shifting ignore the enable
    for (int i = 0; i < 10; i++) begin
      shift1(i[0]);
      chk("R8 cascade0", {15'd0, casc0}, {15'd0, model[7]});
      chk("R8 cascade1", {15'd0, casc1}, {15'd0, model[15]});
    end
    oe_n = 1'b0;
    #1;
    store1();
    chk("R8 shift under oe", {par1, par0}, model);

    // R1/R5: clear between edges
    for (int i = 15; i >= 0; i--) shift1(16'h5A3C >> i);
    store1();
    for (int i = 0; i < 4; i++) shift1(1'b1);
    rst_n = 1'b0;
    #1;
    chk("R1 cascade0 cleared", {15'd0, casc0}, 16'h0000);
    chk("R1 cascade1 cleared", {15'd0, casc1}, 16'h0000);
    chk("R5 hold kept", {par1, par0}, 16'h5A3C);
    model = '0;
    store1();
    chk("R1 store during clear", {par1, par0}, 16'h0000);
    rst_n = 1'b1;
    #4;

    // R10: 16-bit words through the chain
    for (int k = 0; k < 64; k++) begin
      logic [15:0] w;
      w = 16'(k * 16'h0405) ^ 16'h9C31;
      for (int i = 15; i >= 0; i--) shift1(w[i]);
      store1();
      chk("R10 chain word", {par1, par0}, w);
      chk("R10 chain cascade", {15'd0, casc1}, {15'd0, w[15]});
    end

    finish_run();
  end
endmodule